// File: doc/BRIEF.md
# Page-Windowed Flash Tunnel

This block lets a host reach a byte-addressed flash store through a fixed 256-byte window. The host first selects a page by writing a page number into two byte-wide registers on a small register bus. A pulse on the burst start input then opens a transfer on that page. The transfer can be a write or a read, and it always begins at offset 0 of the page. Data bytes then move one at a time through a separate data port. Each byte advances an internal pointer that stays inside the page.

The flash store is modelled as an on-chip byte array, written so that block RAM can be inferred. The page number is 16 bits wide, which covers a 24-bit byte address space. Only the low page-number bits that select a page of the internal array are used. A write burst must open with an offset byte equal to zero. A burst whose offset byte is nonzero is thrown away whole and raises a sticky error. Stored content changes only while a hardware-write gate register is set.

Top module: `page_window_tunnel`

## Requirements
- R1: After reset the page number is 0, the write gate is closed, `page_err` is 0 and `rd_valid` is 0. A read burst opened straight after reset therefore reads page 0.
- R2: A register write to address 0x8E sets page-number bits 7:0, which are flash address bits 15:8. A write to 0x8F sets page-number bits 15:8, which are flash address bits 23:16. Writes to any other address leave the page number unchanged. The page used is the page number modulo NUM_PAGES (default 8).
- R3: A register write to 0xB0 with a nonzero value opens the write gate, and writing 0x00 closes it. While the gate is closed, write-burst data bytes leave the stored content unchanged.
- R4: A `burst_start` pulse captures the page number and resets the byte pointer to offset 0. Page-register writes made after that pulse take effect only at the next `burst_start`.
- R5: In a write burst (`burst_write`=1 at start), the first `byte_valid` byte is the offset byte. When it is 0x00, each following byte is stored at offsets 0, 1, 2 and so on of the captured page.
- R6: A nonzero offset byte causes every byte of that burst to be discarded. It also sets `page_err` one cycle later, and `page_err` then stays 1 until reset.
- R7: In a read burst (`burst_write`=0 at start), each `rd_req` cycle returns the next byte of the page, starting at offset 0. `rd_valid` and `rd_byte` are valid in the cycle after the request.
- R8: The byte pointer wraps from 255 to 0. The 257th data byte of a burst therefore goes to, or comes from, offset 0.
- R9: An `rd_req` outside a read burst gives no `rd_valid` and moves no pointer. A `byte_valid` inside a read burst neither stores data nor moves the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| burst_start | input | 1 | One-cycle pulse that opens a burst |
| burst_write | input | 1 | Burst direction at start: 1 write, 0 read |
| byte_valid | input | 1 | Write-burst byte present on byte_in |
| byte_in | input | 8 | Write-burst byte |
| rd_req | input | 1 | Request for the next read-burst byte |
| rd_valid | output | 1 | rd_byte holds a requested byte |
| rd_byte | output | 8 | Read-burst byte |
| page_err | output | 1 | Sticky flag for a nonzero offset byte |

## Verification
Register writes, burst starts and write bytes each take effect at the clock edge that samples them. A stimulus applied in one cycle therefore governs the very next cycle. A read byte appears one cycle after its request, and `page_err` rises one cycle after the bad offset byte. The bench drives every input on the falling edge and samples each result one time unit after the rising edge that produces it. It checks stored content only by reading it back through a later read burst, compared against a model the bench itself builds from R2, R3, R5 and R8.

// File: rtl/ftun_pkg.sv
package ftun_pkg;
  // Register bus addresses
  localparam logic [7:0] PAGE_REG_BASE = 8'h8E;  // low page byte, high follows
  localparam logic [7:0] GATE_REG_ADDR = 8'hB0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_OFS,
    ST_W_DATA,
    ST_W_DROP,
    ST_READ
  } tun_state_t;
endpackage

// File: rtl/ftun_regs.sv
module ftun_regs #(
  parameter int NUM_PAGE_REGS = 2,
  parameter logic [7:0] BASE_ADDR = ftun_pkg::PAGE_REG_BASE,
  parameter logic [7:0] GATE_ADDR = ftun_pkg::GATE_REG_ADDR,
  localparam int PAGE_W = NUM_PAGE_REGS * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [PAGE_W-1:0] page_q,
  output logic              hw_en
);
  // One byte register per slice of the page number, at consecutive addresses
  for (genvar g = 0; g < NUM_PAGE_REGS; g++) begin : g_page
    localparam logic [7:0] MY_ADDR = BASE_ADDR + 8'(g);
    always_ff @(posedge clk) begin
      if (rst)
        page_q[g*8 +: 8] <= '0;
      else if (reg_we && reg_addr == MY_ADDR)
        page_q[g*8 +: 8] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      hw_en <= 1'b0;
    else if (reg_we && reg_addr == GATE_ADDR)
      hw_en <= (reg_wdata != 8'h00);
  end
endmodule

// File: rtl/ftun_ctrl.sv
module ftun_ctrl #(
  parameter int PAGE_W = 16,
  parameter int PG_SEL_W = 3,
  parameter int PTR_W = 8,
  localparam int AW = PG_SEL_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_start,
  input  logic              burst_write,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in,
  input  logic              rd_req,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              hw_en,
  output logic              mem_we,
  output logic              mem_re,
  output logic [AW-1:0]     mem_addr,
  output logic [PTR_W-1:0]  ptr,
  output logic              page_err,
  output logic              rd_valid
);
  import ftun_pkg::*;

  tun_state_t            state;
  logic [PAGE_W-1:0]     act_page;
  logic                  take_byte;
  logic                  take_read;

  // A start pulse overrides any data activity in the same cycle
  assign take_byte = !burst_start && byte_valid && (state == ST_W_DATA);
  assign take_read = !burst_start && rd_req && (state == ST_READ);

  assign mem_we   = take_byte && hw_en;
  assign mem_re   = take_read;
  assign mem_addr = {act_page[PG_SEL_W-1:0], ptr};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      act_page <= '0;
      ptr      <= '0;
      page_err <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= take_read;
      if (burst_start) begin
        act_page <= page_in;
        ptr      <= '0;
        state    <= burst_write ? ST_W_OFS : ST_READ;
      end else begin
        unique case (state)
          ST_W_OFS: begin
            if (byte_valid) begin
              if (byte_in == 8'h00) begin
                state <= ST_W_DATA;
              end else begin
                state    <= ST_W_DROP;
                page_err <= 1'b1;
              end
            end
          end
          ST_W_DATA: if (take_byte) ptr <= ptr + 1'b1;
          ST_READ:   if (take_read) ptr <= ptr + 1'b1;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ftun_mem.sv
module ftun_mem #(
  parameter int AW = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          re,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    if (re) rdata <= store[addr];
  end
endmodule

// File: rtl/page_window_tunnel.sv
module page_window_tunnel #(
  parameter int NUM_PAGES = 8,
  parameter int WIN_BYTES = 256,
  parameter int NUM_PAGE_REGS = 2,
  localparam int PTR_W = $clog2(WIN_BYTES),
  localparam int PG_SEL_W = $clog2(NUM_PAGES),
  localparam int PAGE_W = NUM_PAGE_REGS * 8,
  localparam int AW = PG_SEL_W + PTR_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       burst_start,
  input  logic       burst_write,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  input  logic       rd_req,
  output logic       rd_valid,
  output logic [7:0] rd_byte,
  output logic       page_err
);
  logic [PAGE_W-1:0] page_q;
  logic              hw_en;
  logic              mem_we;
  logic              mem_re;
  logic [AW-1:0]     mem_addr;
  logic [PTR_W-1:0]  ptr;

  ftun_regs #(.NUM_PAGE_REGS(NUM_PAGE_REGS)) regs_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .page_q(page_q), .hw_en(hw_en)
  );

  ftun_ctrl #(.PAGE_W(PAGE_W), .PG_SEL_W(PG_SEL_W), .PTR_W(PTR_W)) ctrl_i (
    .clk(clk), .rst(rst), .burst_start(burst_start), .burst_write(burst_write),
    .byte_valid(byte_valid), .byte_in(byte_in), .rd_req(rd_req),
    .page_in(page_q), .hw_en(hw_en), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .ptr(ptr), .page_err(page_err), .rd_valid(rd_valid)
  );

  ftun_mem #(.AW(AW)) mem_i (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(byte_in),
    .re(mem_re), .rdata(rd_byte)
  );
endmodule

// File: rtl/ftun_checker.sv
module ftun_checker #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             burst_start,
  input logic             byte_valid,
  input logic [7:0]       byte_in,
  input logic             rd_req,
  input logic             rd_valid,
  input logic             page_err,
  input logic             mem_we,
  input logic             hw_en,
  input logic [PTR_W-1:0] ptr
);
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    page_err |=> page_err);

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(page_err) |-> ($past(byte_valid) && $past(byte_in) != 8'h00));

  assert_gate_closed_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> hw_en);

  assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (rst)
    burst_start |=> (ptr == '0));

  assert_rd_valid_after_req_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req));
endmodule

bind page_window_tunnel ftun_checker #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst(rst), .burst_start(burst_start), .byte_valid(byte_valid),
  .byte_in(byte_in), .rd_req(rd_req), .rd_valid(rd_valid), .page_err(page_err),
  .mem_we(mem_we), .hw_en(hw_en), .ptr(ptr)
);

// File: tb/page_window_tunnel_tb.sv
module page_window_tunnel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPAGES = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       burst_start = 1'b0;
  logic       burst_write = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = '0;
  logic       rd_req = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_byte;
  logic       page_err;

  int n_total = 0;
  int n_fail = 0;
  logic [7:0] model [NPAGES][256];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_window_tunnel dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .burst_start(burst_start), .burst_write(burst_write),
    .byte_valid(byte_valid), .byte_in(byte_in), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .page_err(page_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * 7 + seed * 13 + 5) & 255);
  endfunction

  task automatic pulse_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic set_page(input logic [15:0] p);
    reg_write(8'h8E, p[7:0]);
    reg_write(8'h8F, p[15:8]);
  endtask

  task automatic start(input logic w);
    @(negedge clk); burst_start = 1'b1; burst_write = w;
    @(negedge clk); burst_start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; byte_in = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic read1(output logic v, output logic [7:0] d);
    @(negedge clk); rd_req = 1'b1;
    @(posedge clk); #1;
    v = rd_valid; d = rd_byte;
    rd_req = 1'b0;
  endtask

  // Write n bytes of a pattern to page p (offset byte 0 first); model updated if stored
  task automatic write_page(input logic [15:0] p, input int n, input int seed, input logic stored);
    set_page(p);
    start(1'b1);
    send(8'h00);
    for (int i = 0; i < n; i++) begin
      send(pat(seed, i));
      if (stored) model[int'(p) % NPAGES][i % 256] = pat(seed, i);
    end
  endtask

  task automatic read_expect(input string tag, input int pg, input int first, input int n);
    logic v; logic [7:0] d;
    for (int i = first; i < first + n; i++) begin
      read1(v, d);
      check({tag, " rd_valid"}, 32'(v), 32'd1);
      check({tag, " data"}, 32'(d), 32'(model[pg][i % 256]));
    end
  endtask

  task automatic t_reset();
    write_page(16'd0, 16, 1, 1'b0);   // gate closed after first reset: nothing stored
    reg_write(8'hB0, 8'h01);
    write_page(16'd0, 16, 1, 1'b1);
    write_page(16'd3, 16, 2, 1'b1);
    set_page(16'd5);
    pulse_reset();
    #1;
    check("R1 page_err after reset", 32'(page_err), 32'd0);
    check("R1 rd_valid after reset", 32'(rd_valid), 32'd0);
    start(1'b0);                       // page number must be back to 0
    read_expect("R1 page zero", 0, 0, 16);
    write_page(16'd3, 16, 9, 1'b0);    // gate closed by reset
    start(1'b0);
    read_expect("R1 gate closed", 3, 0, 16);
  endtask

  task automatic t_basic();
    reg_write(8'hB0, 8'h3C);
    write_page(16'd2, 32, 3, 1'b1);
    start(1'b0);
    read_expect("R5 R7 basic", 2, 0, 32);
  endtask

  task automatic t_alias();
    write_page(16'd9, 8, 4, 1'b1);       // 9 mod 8 = page 1
    set_page(16'h0101);                  // 257 mod 8 = page 1
    start(1'b0);
    read_expect("R2 high byte alias", 1, 0, 8);
    set_page(16'd2);
    reg_write(8'h8D, 8'h04);             // not a page register
    reg_write(8'h90, 8'h04);
    start(1'b0);
    read_expect("R2 other address", 2, 0, 4);
  endtask

  task automatic t_gate();
    write_page(16'd4, 16, 5, 1'b1);
    reg_write(8'hB0, 8'h00);
    write_page(16'd4, 16, 6, 1'b0);
    start(1'b0);
    read_expect("R3 gate zero", 4, 0, 16);
    reg_write(8'hB0, 8'h80);
  endtask

  task automatic t_mid_burst();
    set_page(16'd2);
    start(1'b0);
    read_expect("R4 before change", 2, 0, 3);
    set_page(16'd4);
    read_expect("R4 page held", 2, 3, 3);
    start(1'b0);
    read_expect("R4 next start", 4, 0, 3);
  endtask

  task automatic t_bad_offset();
    check("R6 no error yet", 32'(page_err), 32'd0);
    set_page(16'd2);
    start(1'b1);
    send(8'h5A);
    #1;
    check("R6 err set", 32'(page_err), 32'd1);
    for (int i = 0; i < 8; i++) send(8'hA5);
    start(1'b0);
    read_expect("R6 burst discarded", 2, 0, 8);
    write_page(16'd2, 4, 7, 1'b1);
    check("R6 err sticky", 32'(page_err), 32'd1);
    start(1'b0);
    read_expect("R6 good burst after", 2, 0, 4);
  endtask

  task automatic t_wrap();
    write_page(16'd6, 256, 8, 1'b1);
    send(8'hEE);
    model[6][0] = 8'hEE;
    start(1'b0);
    read_expect("R8 wrap", 6, 0, 257);
  endtask

  task automatic t_ignored();
    logic v; logic [7:0] d;
    set_page(16'd2);
    start(1'b1);
    read1(v, d);
    check("R9 rd_req in write burst", 32'(v), 32'd0);
    start(1'b0);
    send(8'h77);
    read_expect("R9 byte in read burst", 2, 0, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    pulse_reset();
    t_reset();
    t_basic();
    t_alias();
    t_gate();
    t_mid_burst();
    t_bad_offset();
    t_wrap();
    t_ignored();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule